// File: doc/BRIEF.md
# Data address watchpoint unit

This block watches every data access leaving a processor's load/store path and decides whether it should raise a debug event. It has two watchpoint channels, and each channel compares the effective address against a programmed value. The two compare values can serve as two independent exact-match points. They can also be fused into one channel 1 watchpoint, which is then either a value-plus-mask bit match, an inclusive window, or an exclusive (outside-the-window) test.

Each channel carries two qualifiers. The first restricts hits to supervisor or user state. The second restricts them to one data address space. A channel can also be tied to an instruction-address hit of the same instruction, so that it fires only when both occur. Channel 1 is tied to instruction comparator 1 and channel 2 to instruction comparator 3. When a channel is tied in this way, the instruction hit is absorbed and does not report on its own.

The block reports four event pulses: the two data channels and the two pass-through instruction hits. Each pulse arrives one clock after the access and also sets a sticky status bit. Software programs the block through a small write port, which holds a control word, the two compare values and a write-one-to-clear status register.

Top module: `daddr_watch`

## Requirements
- R1: After reset all event outputs and status bits are 0, the control word is 0 (exact mode, no qualifiers, no links) and both compare values are 0, so a valid access to address 0 hits both channels.
- R2: A write with `cfg_we`=1 lands in register `cfg_addr` (0 control, 1 compare value 1, 2 compare value 2, 3 status clear). It affects accesses presented from the next cycle on; an access in the same cycle as the write still sees the old contents.
- R3: Control word layout: bits[1:0] channel 1 privilege qualifier, [3:2] channel 1 space qualifier, [5:4] channel 2 privilege qualifier, [7:6] channel 2 space qualifier, [9:8] compare mode, [10] channel 1 link, [11] channel 2 link. In mode 0 (exact), channel 1 hits when the address equals value 1, and channel 2 hits independently when the address equals value 2.
- R4: In mode 1 (bit match), channel 1 hits when (address AND value 2) equals (value 1 AND value 2).
- R5: In mode 2 (inclusive range), channel 1 hits when value 1 <= address < value 2, unsigned.
- R6: In mode 3 (exclusive range), channel 1 hits when address < value 1 or address >= value 2, unsigned.
- R7: In modes 1, 2 and 3 channel 2 never signals, and channel 2's qualifiers have no effect on channel 1.
- R8: Privilege qualifier: 00 allows any state, 10 allows a hit only with `acc_priv`=0, 11 only with `acc_priv`=1, and 01 never allows a hit.
- R9: Space qualifier: 00 allows any space, 10 allows a hit only with `acc_space`=0, 11 only with `acc_space`=1, and 01 never allows a hit.
- R10: With channel 1 linked, channel 1 fires only if `iac1_hit` is also set, and `iac1_hit` raises no `evt_iac1` and no status. With the link clear, a valid access carrying `iac1_hit` raises `evt_iac1`.
- R11: With channel 2 linked in exact mode, channel 2 fires only if `iac3_hit` is also set, and `iac3_hit` is absorbed. In the other modes the channel 2 link has no effect and `iac3_hit` raises `evt_iac3`.
- R12: Event pulses are registered: an event appears for exactly one cycle, on the clock after a valid access. An access with `acc_valid`=0 produces none.
- R13: Status bits (0 channel 1, 1 channel 2, 2 instruction hit 1, 3 instruction hit 3) are set together with their event and stay set until a 1 is written to that bit at register 3. A bit set and cleared in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | RAW (2) | Register index |
| cfg_wdata | input | AW (32) | Register write data |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_addr | input | AW (32) | Effective address of the access |
| acc_priv | input | 1 | Privilege state, 1 = user |
| acc_space | input | 1 | Data address-space bit |
| iac1_hit | input | 1 | Instruction comparator 1 hit for the same instruction |
| iac3_hit | input | 1 | Instruction comparator 3 hit for the same instruction |
| evt_ch1 | output | 1 | Channel 1 data event pulse |
| evt_ch2 | output | 1 | Channel 2 data event pulse |
| evt_iac1 | output | 1 | Unlinked instruction hit 1 event pulse |
| evt_iac3 | output | 1 | Unlinked instruction hit 3 event pulse |
| sts | output | 4 | Sticky status bits |

## Verification
Every result of this block is due exactly one clock after the cycle in which its stimulus is driven. This holds for the four event pulses and for the status update, including a clear. A register write counts only for accesses in later cycles.

The driver changes inputs on the falling edge and pushes the expected events and status for that cycle into a queue. It predicts these values from its own copy of the registers as they stood before that cycle's write. The monitor pops one entry a quarter period after each following rising edge, so each comparison falls in the single cycle where the pulse is defined. This also lets idle cycles prove that no stray pulse appears.

// File: rtl/daddr_watch_pkg.sv
package daddr_watch_pkg;

   localparam int NCH   = 2;
   localparam int STS_W = 4;

   localparam int STS_CH1  = 0;
   localparam int STS_CH2  = 1;
   localparam int STS_IAC1 = 2;
   localparam int STS_IAC3 = 3;

   typedef enum logic [1:0] {
      CMP_EXACT = 2'b00,
      CMP_BITS  = 2'b01,
      CMP_INCL  = 2'b10,
      CMP_EXCL  = 2'b11
   } cmp_mode_e;

   // control word, first member is the most significant
   typedef struct packed {
      logic      link2;
      logic      link1;
      cmp_mode_e mode;
      logic [1:0] sp2;
      logic [1:0] pv2;
      logic [1:0] sp1;
      logic [1:0] pv1;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/daddr_qual.sv
// Privilege and address-space qualifier of one channel.
module daddr_qual (
   input  logic [1:0] priv_sel,
   input  logic [1:0] space_sel,
   input  logic       priv,
   input  logic       space,
   output logic       ok
);
   logic priv_ok;
   logic space_ok;

   always_comb begin
      unique case (priv_sel)
         2'b00:   priv_ok = 1'b1;
         2'b10:   priv_ok = ~priv;
         2'b11:   priv_ok = priv;
         default: priv_ok = 1'b0;   // reserved code never qualifies
      endcase
      unique case (space_sel)
         2'b00:   space_ok = 1'b1;
         2'b10:   space_ok = ~space;
         2'b11:   space_ok = space;
         default: space_ok = 1'b0;  // real-address mode: no hit possible
      endcase
   end

   assign ok = priv_ok & space_ok;
endmodule

// File: rtl/daddr_cmp.sv
// Address comparators shared by both channels.
module daddr_cmp
   import daddr_watch_pkg::*;
#(
   parameter int AW = 32
) (
   input  cmp_mode_e        mode,
   input  logic [AW-1:0]    addr,
   input  logic [AW-1:0]    val1,
   input  logic [AW-1:0]    val2,
   output logic             raw1,
   output logic             raw2
);
   logic eq1, eq2, ge1, lt2, masked;

   assign eq1    = (addr == val1);
   assign eq2    = (addr == val2);
   assign ge1    = (addr >= val1);
   assign lt2    = (addr <  val2);
   assign masked = (((addr ^ val1) & val2) == '0);

   always_comb begin
      unique case (mode)
         CMP_EXACT: raw1 = eq1;
         CMP_BITS:  raw1 = masked;
         CMP_INCL:  raw1 = ge1 & lt2;
         CMP_EXCL:  raw1 = ~ge1 | ~lt2;
         default:   raw1 = 1'b0;
      endcase
   end

   assign raw2 = (mode == CMP_EXACT) & eq2;
endmodule

// File: rtl/daddr_regs.sv
// Control word and compare values.
module daddr_regs
   import daddr_watch_pkg::*;
#(
   parameter int AW  = 32,
   parameter int RAW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [RAW-1:0] cfg_addr,
   input  logic [AW-1:0]  cfg_wdata,
   output ctl_t           ctl,
   output logic [AW-1:0]  val1,
   output logic [AW-1:0]  val2
);
   localparam logic [RAW-1:0] IDX_CTL = RAW'(0);
   localparam logic [RAW-1:0] IDX_V1  = RAW'(1);
   localparam logic [RAW-1:0] IDX_V2  = RAW'(2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl  <= '0;
         val1 <= '0;
         val2 <= '0;
      end else if (cfg_we) begin
         if (cfg_addr == IDX_CTL) ctl  <= ctl_t'(cfg_wdata[CTL_W-1:0]);
         if (cfg_addr == IDX_V1)  val1 <= cfg_wdata;
         if (cfg_addr == IDX_V2)  val2 <= cfg_wdata;
      end
   end

   // R2: a written compare value is visible on the next cycle
   AST_V1_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == IDX_V1) |=> (val1 == $past(cfg_wdata))) else $error("v1 write lost"); // R2
endmodule

// File: rtl/daddr_watch.sv
module daddr_watch
   import daddr_watch_pkg::*;
#(
   parameter int AW  = 32,
   parameter int RAW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [RAW-1:0] cfg_addr,
   input  logic [AW-1:0]  cfg_wdata,
   input  logic           acc_valid,
   input  logic [AW-1:0]  acc_addr,
   input  logic           acc_priv,
   input  logic           acc_space,
   input  logic           iac1_hit,
   input  logic           iac3_hit,
   output logic           evt_ch1,
   output logic           evt_ch2,
   output logic           evt_iac1,
   output logic           evt_iac3,
   output logic [STS_W-1:0] sts
);
   localparam logic [RAW-1:0] IDX_STS = RAW'(3);

   if (AW < CTL_W) begin : g_bad_aw
      $error("AW must hold the control word");
   end
   if (RAW < 2) begin : g_bad_raw
      $error("RAW must address four registers");
   end

   ctl_t          ctl;
   logic [AW-1:0] val1, val2;

   daddr_regs #(.AW(AW), .RAW(RAW)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .ctl(ctl), .val1(val1), .val2(val2)
   );

   logic raw1, raw2;
   daddr_cmp #(.AW(AW)) u_cmp (
      .mode(ctl.mode), .addr(acc_addr), .val1(val1), .val2(val2),
      .raw1(raw1), .raw2(raw2)
   );

   logic [1:0] pv_sel [NCH];
   logic [1:0] sp_sel [NCH];
   logic [NCH-1:0] qok;

   assign pv_sel[0] = ctl.pv1;
   assign sp_sel[0] = ctl.sp1;
   assign pv_sel[1] = ctl.pv2;
   assign sp_sel[1] = ctl.sp2;

   for (genvar g = 0; g < NCH; g++) begin : g_qual
      daddr_qual u_q (
         .priv_sel(pv_sel[g]), .space_sel(sp_sel[g]),
         .priv(acc_priv), .space(acc_space), .ok(qok[g])
      );
   end

   logic exact;
   logic [STS_W-1:0] nxt;
   logic [STS_W-1:0] clr;

   assign exact = (ctl.mode == CMP_EXACT);
   assign nxt[STS_CH1]  = acc_valid & raw1 & qok[0] & (~ctl.link1 | iac1_hit);
   assign nxt[STS_CH2]  = acc_valid & raw2 & qok[1] & (~ctl.link2 | iac3_hit);
   assign nxt[STS_IAC1] = acc_valid & iac1_hit & ~ctl.link1;
   assign nxt[STS_IAC3] = acc_valid & iac3_hit & ~(ctl.link2 & exact);
   assign clr = (cfg_we && cfg_addr == IDX_STS) ? cfg_wdata[STS_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_ch1  <= 1'b0;
         evt_ch2  <= 1'b0;
         evt_iac1 <= 1'b0;
         evt_iac3 <= 1'b0;
         sts      <= '0;
      end else begin
         evt_ch1  <= nxt[STS_CH1];
         evt_ch2  <= nxt[STS_CH2];
         evt_iac1 <= nxt[STS_IAC1];
         evt_iac3 <= nxt[STS_IAC3];
         sts      <= (sts & ~clr) | nxt;
      end
   end

   AST_NO_EVT_WITHOUT_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_ch1 | evt_ch2 | evt_iac1 | evt_iac3) |-> $past(acc_valid)) else $error("event without access"); // R12
   AST_CH2_EXACT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      evt_ch2 |-> ($past(ctl.mode) == CMP_EXACT)) else $error("ch2 fired in fused mode"); // R7
   AST_LINK1_NEEDS_IAC: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_ch1 && $past(ctl.link1)) |-> $past(iac1_hit)) else $error("linked ch1 without iac1"); // R10
   AST_IAC1_ABSORBED: assert property (@(posedge clk) disable iff (!rst_n)
      evt_iac1 |-> !$past(ctl.link1)) else $error("absorbed iac1 reported"); // R10
   AST_IAC3_ABSORBED: assert property (@(posedge clk) disable iff (!rst_n)
      evt_iac3 |-> !($past(ctl.link2) && $past(ctl.mode) == CMP_EXACT)) else $error("absorbed iac3 reported"); // R11
   AST_RSVD_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      evt_ch1 |-> ($past(ctl.pv1) != 2'b01)) else $error("reserved privilege code hit"); // R8
   AST_RSVD_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_ch1 |-> ($past(ctl.sp1) != 2'b01)) else $error("real-address code hit"); // R9
   AST_EVT_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_ch1 |-> sts[STS_CH1]) else $error("status not set"); // R13
   AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sts[STS_CH1]) && !$past(cfg_we && cfg_addr == IDX_STS && cfg_wdata[STS_CH1]))
         |-> sts[STS_CH1]) else $error("status dropped"); // R13
endmodule

// File: tb/daddr_watch_test.sv
module daddr_watch_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_priv = 1'b0;
   logic        acc_space = 1'b0;
   logic        iac1_hit = 1'b0;
   logic        iac3_hit = 1'b0;
   logic        evt_ch1, evt_ch2, evt_iac1, evt_iac3;
   logic [3:0]  sts;

   int total = 0;
   int bad = 0;

   daddr_watch #(.AW(32), .RAW(2)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_priv(acc_priv), .acc_space(acc_space), .iac1_hit(iac1_hit),
      .iac3_hit(iac3_hit), .evt_ch1(evt_ch1), .evt_ch2(evt_ch2),
      .evt_iac1(evt_iac1), .evt_iac3(evt_iac3), .sts(sts)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // bench copy of the programmed registers
   logic [31:0] sh_ctl = '0, sh_v1 = '0, sh_v2 = '0;
   logic [3:0]  sh_sts = '0;

   logic [3:0] q_ev [$];
   logic [3:0] q_st [$];
   string      q_tag [$];

   function automatic logic qual(input logic [1:0] s, input logic b);
      return (s == 2'b00) || (s == 2'b10 && !b) || (s == 2'b11 && b);
   endfunction

   function automatic logic [31:0] mk_ctl(input logic [1:0] pv1, input logic [1:0] sp1,
                                          input logic [1:0] pv2, input logic [1:0] sp2,
                                          input logic [1:0] mode, input logic l1, input logic l2);
      return {20'd0, l2, l1, mode, sp2, pv2, sp1, pv1};
   endfunction

   function automatic logic [3:0] predict(input logic v, input logic [31:0] a, input logic pr,
                                          input logic sp, input logic i1, input logic i3);
      logic [1:0] mode;
      logic r1, r2, h1, h2, e1, e3;
      mode = sh_ctl[9:8];
      r2 = 1'b0;
      case (mode)
         2'd0: begin r1 = (a == sh_v1); r2 = (a == sh_v2); end
         2'd1: r1 = ((a & sh_v2) == (sh_v1 & sh_v2));
         2'd2: r1 = (a >= sh_v1) && (a < sh_v2);
         default: r1 = (a < sh_v1) || (a >= sh_v2);
      endcase
      h1 = v && r1 && qual(sh_ctl[1:0], pr) && qual(sh_ctl[3:2], sp) && (!sh_ctl[10] || i1);
      h2 = v && r2 && qual(sh_ctl[5:4], pr) && qual(sh_ctl[7:6], sp) && (!sh_ctl[11] || i3);
      e1 = v && i1 && !sh_ctl[10];
      e3 = v && i3 && !(sh_ctl[11] && mode == 2'd0);
      return {e3, e1, h2, h1};
   endfunction

   task automatic step(input logic we, input logic [1:0] wa, input logic [31:0] wd,
                       input logic v, input logic [31:0] a, input logic pr, input logic sp,
                       input logic i1, input logic i3, input string tag);
      logic [3:0] ev, clr;
      @(negedge clk);
      cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
      acc_valid = v; acc_addr = a; acc_priv = pr; acc_space = sp;
      iac1_hit = i1; iac3_hit = i3;
      ev  = predict(v, a, pr, sp, i1, i3);
      clr = (we && wa == 2'd3) ? wd[3:0] : 4'd0;
      sh_sts = (sh_sts & ~clr) | ev;
      q_ev.push_back(ev);
      q_st.push_back(sh_sts);
      q_tag.push_back(tag);
      if (we) begin
         case (wa)
            2'd0: sh_ctl = wd;
            2'd1: sh_v1  = wd;
            2'd2: sh_v2  = wd;
            default: ;
         endcase
      end
   endtask

   task automatic wr(input logic [1:0] wa, input logic [31:0] wd, input string tag);
      step(1'b1, wa, wd, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
   endtask

   task automatic acc(input logic [31:0] a, input logic pr, input logic sp,
                      input logic i1, input logic i3, input string tag);
      step(1'b0, 2'd0, 32'd0, 1'b1, a, pr, sp, i1, i3, tag);
   endtask

   // monitor: results are due one clock after the driven cycle
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (q_ev.size() > 0) begin
            logic [3:0] ee, es, got;
            string t;
            ee = q_ev.pop_front();
            es = q_st.pop_front();
            t  = q_tag.pop_front();
            got = {evt_iac3, evt_iac1, evt_ch2, evt_ch1};
            total++;
            if (got !== ee || sts !== es) begin
               bad++;
               $display("FAIL %s: events=%b sts=%b expected events=%b sts=%b", t, got, sts, ee, es);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      total++;
      if ({evt_iac3, evt_iac1, evt_ch2, evt_ch1, sts} !== 8'h00) begin
         bad++;
         $display("FAIL R1: outputs=%b expected=%b", {evt_iac3, evt_iac1, evt_ch2, evt_ch1, sts}, 8'h00);
      end
      rst_n = 1'b1;

      // R1: reset values make address 0 hit both channels
      acc(32'h0, 1'b0, 1'b0, 1'b1, 1'b1, "R1");

      // R2 / R3: exact compares
      wr(2'd1, 32'h1000, "R2");
      wr(2'd2, 32'h2000, "R2");
      acc(32'h1000, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
      acc(32'h2000, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
      acc(32'h1001, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
      step(1'b1, 2'd1, 32'h3000, 1'b1, 32'h3000, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
      acc(32'h3000, 1'b0, 1'b0, 1'b0, 1'b0, "R2");

      // R8: privilege qualifier
      wr(2'd0, mk_ctl(2'b10, 2'b00, 2'b11, 2'b00, 2'd0, 1'b0, 1'b0), "R8");
      acc(32'h3000, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
      acc(32'h3000, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
      acc(32'h2000, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
      acc(32'h2000, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
      wr(2'd0, mk_ctl(2'b01, 2'b00, 2'b00, 2'b00, 2'd0, 1'b0, 1'b0), "R8");
      acc(32'h3000, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
      acc(32'h3000, 1'b1, 1'b0, 1'b0, 1'b0, "R8");

      // R9: space qualifier
      wr(2'd0, mk_ctl(2'b00, 2'b11, 2'b00, 2'b10, 2'd0, 1'b0, 1'b0), "R9");
      acc(32'h3000, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
      acc(32'h3000, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
      acc(32'h2000, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
      acc(32'h2000, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
      wr(2'd0, mk_ctl(2'b00, 2'b01, 2'b00, 2'b00, 2'd0, 1'b0, 1'b0), "R9");
      acc(32'h3000, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
      acc(32'h3000, 1'b0, 1'b1, 1'b0, 1'b0, "R9");

      // R12: no access, no event
      wr(2'd0, 32'h0, "R12");
      step(1'b0, 2'd0, 32'd0, 1'b0, 32'h3000, 1'b0, 1'b0, 1'b1, 1'b1, "R12");
      acc(32'h3000, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
      step(1'b0, 2'd0, 32'd0, 1'b0, 32'h3000, 1'b0, 1'b0, 1'b0, 1'b0, "R12");

      // R4: bit match
      wr(2'd0, mk_ctl(2'b00, 2'b00, 2'b00, 2'b00, 2'd1, 1'b0, 1'b0), "R4");
      wr(2'd1, 32'h0000_1230, "R4");
      wr(2'd2, 32'hFFFF_FFF0, "R4");
      acc(32'h1235, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
      acc(32'h1245, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
      acc(32'hFFFF_FFF0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");

      // R5: inclusive range
      wr(2'd0, mk_ctl(2'b00, 2'b00, 2'b00, 2'b00, 2'd2, 1'b0, 1'b0), "R5");
      wr(2'd1, 32'h100, "R5");
      wr(2'd2, 32'h200, "R5");
      acc(32'h0FF, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      acc(32'h100, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      acc(32'h1FF, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      acc(32'h200, 1'b0, 1'b0, 1'b0, 1'b0, "R5");

      // R6: exclusive range
      wr(2'd0, mk_ctl(2'b00, 2'b00, 2'b00, 2'b00, 2'd3, 1'b0, 1'b0), "R6");
      acc(32'h0FF, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
      acc(32'h100, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
      acc(32'h1FF, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
      acc(32'h200, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
      acc(32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R6");

      // R7: fused mode uses only channel 1 qualifiers
      wr(2'd0, mk_ctl(2'b00, 2'b00, 2'b01, 2'b01, 2'd2, 1'b0, 1'b0), "R7");
      acc(32'h150, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
      wr(2'd0, mk_ctl(2'b00, 2'b01, 2'b00, 2'b00, 2'd2, 1'b0, 1'b0), "R7");
      acc(32'h150, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
      acc(32'h200, 1'b0, 1'b0, 1'b0, 1'b0, "R7");

      // R10: channel 1 link
      wr(2'd0, mk_ctl(2'b00, 2'b00, 2'b00, 2'b00, 2'd0, 1'b1, 1'b0), "R10");
      wr(2'd1, 32'h4000, "R10");
      acc(32'h4000, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
      acc(32'h4000, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
      acc(32'h5000, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
      wr(2'd0, 32'h0, "R10");
      acc(32'h5000, 1'b0, 1'b0, 1'b1, 1'b0, "R10");

      // R11: channel 2 link
      wr(2'd3, 32'hF, "R13");
      wr(2'd2, 32'h6000, "R11");
      wr(2'd0, mk_ctl(2'b00, 2'b00, 2'b00, 2'b00, 2'd0, 1'b0, 1'b1), "R11");
      acc(32'h6000, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
      acc(32'h6000, 1'b0, 1'b0, 1'b0, 1'b1, "R11");
      acc(32'h7000, 1'b0, 1'b0, 1'b0, 1'b1, "R11");
      wr(2'd0, mk_ctl(2'b00, 2'b00, 2'b00, 2'b00, 2'd2, 1'b0, 1'b1), "R11");
      acc(32'h0050, 1'b0, 1'b0, 1'b0, 1'b1, "R11");

      // R13: sticky status, write-one-to-clear, set beats clear
      wr(2'd0, 32'h0, "R13");
      acc(32'h4000, 1'b0, 1'b0, 1'b0, 1'b0, "R13");
      step(1'b0, 2'd0, 32'd0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R13");
      wr(2'd3, 32'h1, "R13");
      acc(32'h6000, 1'b0, 1'b0, 1'b0, 1'b0, "R13");
      step(1'b1, 2'd3, 32'h1, 1'b1, 32'h4000, 1'b0, 1'b0, 1'b0, 1'b0, "R13");
      wr(2'd3, 32'h2, "R13");
      wr(2'd3, 32'hF, "R13");

      step(1'b0, 2'd0, 32'd0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule